// File: doc/BRIEF.md
# Trap Entry and Delegation Unit

This unit takes a single trap event and commits every architectural side effect of taking it. A trap event is an interrupt flag, a cause code, a faulting address and the PC of the trapping instruction. The unit picks the handling mode, supervisor or machine, from the current privilege and from two delegation masks: one for exceptions and one for interrupts. It then writes that mode's cause, exception-PC and trap-value registers. It saves the old interrupt-enable and privilege into the status fields, clears the enable, loads the PC with the mode's vector base and switches privilege. All of this happens on one clock edge.

Environment-call causes are rewritten to match the privilege they were raised from. Causes that carry no address clear the trap value. A small context-load port sets privilege and the two interrupt enables. It stands in for the return path that would normally restore them.

Top module: `trap_entry_unit`

## Requirements
- R1: After reset, privilege is machine (encoding U=0, S=1, M=3), the PC equals RESET_PC, and every status, cause, exception-PC and trap-value output is zero.
- R2: For an interrupt, the stored cause has bit 31 set and the interrupt code in the low bits, with all other bits zero.
- R3: An exception with code 8 is stored as 8 from U, 9 from S and 11 from M. Other exception codes are stored unchanged.
- R4: The delegation bit is taken from the interrupt mask for interrupts and from the exception mask for exceptions. The index is the stored cause with bit 31 removed, so a rewritten environment call uses its rewritten code.
- R5: A trap is handled in supervisor mode only when the privilege is U or S and the indexed delegation bit is 1. In every other case it is handled in machine mode, including any trap taken in M.
- R6: A supervisor trap sets PC to the supervisor vector base and writes the supervisor cause and exception PC. It copies the old supervisor enable into the supervisor previous-enable and the old privilege (U→0, S→1) into the supervisor previous-privilege. It clears the supervisor enable and sets privilege to S. All machine cause, exception-PC and trap-value registers are left unchanged.
- R7: A machine trap sets PC to the machine vector base and writes the machine cause and exception PC. It copies the old machine enable into the machine previous-enable and the old privilege into the machine previous-privilege. It clears the machine enable and sets privilege to M. All supervisor cause, exception-PC and trap-value registers are left unchanged.
- R8: The selected trap value takes the faulting address when the trap is an exception with stored cause 0, 1, 4, 5, 6, 7, 12, 13 or 15. For any other exception and for every interrupt it becomes zero.
- R9: In a cycle with neither trap-valid nor context-load, no output changes.
- R10: Context-load sets privilege, supervisor enable and machine enable, and privilege value 2 is stored as U. When trap-valid and context-load are high together, the trap is taken and the load has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| trap_valid | input | 1 | Take the trap this cycle |
| trap_irq | input | 1 | Event is an interrupt |
| trap_code | input | CODE_W | Interrupt or exception code |
| trap_addr | input | XLEN | Faulting address |
| trap_pc | input | XLEN | PC of the trapping instruction |
| svec_base | input | XLEN | Supervisor vector base |
| mvec_base | input | XLEN | Machine vector base |
| exc_deleg | input | XLEN | Exception delegation mask |
| irq_deleg | input | XLEN | Interrupt delegation mask |
| ctx_load | input | 1 | Load privilege and enables |
| ctx_priv | input | 2 | Privilege to load |
| ctx_sie | input | 1 | Supervisor enable to load |
| ctx_mie | input | 1 | Machine enable to load |
| pc_o | output | XLEN | Current PC (redirect target after a trap) |
| priv_o | output | 2 | Current privilege |
| sie_o | output | 1 | Supervisor interrupt enable |
| spie_o | output | 1 | Supervisor previous enable |
| spp_o | output | 1 | Supervisor previous privilege |
| mie_o | output | 1 | Machine interrupt enable |
| mpie_o | output | 1 | Machine previous enable |
| mpp_o | output | 2 | Machine previous privilege |
| scause_o | output | XLEN | Supervisor cause |
| sepc_o | output | XLEN | Supervisor exception PC |
| stval_o | output | XLEN | Supervisor trap value |
| mcause_o | output | XLEN | Machine cause |
| mepc_o | output | XLEN | Machine exception PC |
| mtval_o | output | XLEN | Machine trap value |

## Verification
The bench builds the unit with its defaults: XLEN of 32, CODE_W of 5 and RESET_PC of 0x1000. A 5-bit code spans all 32 delegation bits, so random masks reach every delegation index. The same width covers every address-carrying cause and the environment-call codes 8, 9 and 11. Random codes are skewed toward 0 to 15 so that the trap-value rule and the environment-call remapping are hit often. Directed cases add a trap taken from M with full masks, an interrupt and an exception with the same code under opposite masks, a load of privilege value 2, and a trap that coincides with a context load.

// File: rtl/trap_entry_unit.sv
module trap_entry_unit #(
  parameter int XLEN = 32,
  parameter int CODE_W = 5,
  parameter logic [XLEN-1:0] RESET_PC = 32'h0000_1000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              trap_valid,
  input  logic              trap_irq,
  input  logic [CODE_W-1:0] trap_code,
  input  logic [XLEN-1:0]   trap_addr,
  input  logic [XLEN-1:0]   trap_pc,
  input  logic [XLEN-1:0]   svec_base,
  input  logic [XLEN-1:0]   mvec_base,
  input  logic [XLEN-1:0]   exc_deleg,
  input  logic [XLEN-1:0]   irq_deleg,
  input  logic              ctx_load,
  input  logic [1:0]        ctx_priv,
  input  logic              ctx_sie,
  input  logic              ctx_mie,
  output logic [XLEN-1:0]   pc_o,
  output logic [1:0]        priv_o,
  output logic              sie_o,
  output logic              spie_o,
  output logic              spp_o,
  output logic              mie_o,
  output logic              mpie_o,
  output logic [1:0]        mpp_o,
  output logic [XLEN-1:0]   scause_o,
  output logic [XLEN-1:0]   sepc_o,
  output logic [XLEN-1:0]   stval_o,
  output logic [XLEN-1:0]   mcause_o,
  output logic [XLEN-1:0]   mepc_o,
  output logic [XLEN-1:0]   mtval_o
);
  localparam logic [1:0] LVL_U = 2'd0;
  localparam logic [1:0] LVL_S = 2'd1;
  localparam logic [1:0] LVL_M = 2'd3;
  localparam logic [CODE_W-1:0] ENV_CALL = CODE_W'(8);
  localparam logic [XLEN-1:0] ADDR_CAUSES = XLEN'(32'h0000_B0F3);

  logic [CODE_W-1:0] eff_code;
  logic [XLEN-1:0]   cause_val, tval_val, deleg_vec;
  logic              to_super, has_addr;

  always_comb begin
    eff_code = trap_code;
    if (!trap_irq && trap_code == ENV_CALL) begin
      case (priv_o)
        LVL_U:   eff_code = CODE_W'(8);
        LVL_S:   eff_code = CODE_W'(9);
        default: eff_code = CODE_W'(11);
      endcase
    end
  end

  assign cause_val = trap_irq ? {1'b1, {(XLEN-1-CODE_W){1'b0}}, trap_code}
                              : {{(XLEN-CODE_W){1'b0}}, eff_code};
  assign deleg_vec = trap_irq ? irq_deleg : exc_deleg;
  assign to_super  = (priv_o <= LVL_S) && deleg_vec[eff_code];
  assign has_addr  = !trap_irq && ADDR_CAUSES[eff_code];
  assign tval_val  = has_addr ? trap_addr : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_o     <= RESET_PC;
      priv_o   <= LVL_M;
      sie_o    <= 1'b0;
      spie_o   <= 1'b0;
      spp_o    <= 1'b0;
      mie_o    <= 1'b0;
      mpie_o   <= 1'b0;
      mpp_o    <= 2'd0;
      scause_o <= '0;
      sepc_o   <= '0;
      stval_o  <= '0;
      mcause_o <= '0;
      mepc_o   <= '0;
      mtval_o  <= '0;
    end else if (trap_valid) begin
      if (to_super) begin
        pc_o     <= svec_base;
        scause_o <= cause_val;
        sepc_o   <= trap_pc;
        stval_o  <= tval_val;
        spie_o   <= sie_o;
        spp_o    <= priv_o[0];
        sie_o    <= 1'b0;
        priv_o   <= LVL_S;
      end else begin
        pc_o     <= mvec_base;
        mcause_o <= cause_val;
        mepc_o   <= trap_pc;
        mtval_o  <= tval_val;
        mpie_o   <= mie_o;
        mpp_o    <= priv_o;
        mie_o    <= 1'b0;
        priv_o   <= LVL_M;
      end
    end else if (ctx_load) begin
      priv_o <= (ctx_priv == 2'd2) ? LVL_U : ctx_priv;
      sie_o  <= ctx_sie;
      mie_o  <= ctx_mie;
    end
  end
endmodule

// File: rtl/trap_entry_checks.sv
module trap_entry_checks #(
  parameter int XLEN = 32,
  parameter int CODE_W = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              trap_valid,
  input logic              trap_irq,
  input logic [CODE_W-1:0] trap_code,
  input logic [XLEN-1:0]   trap_pc,
  input logic              ctx_load,
  input logic [XLEN-1:0]   pc_o,
  input logic [1:0]        priv_o,
  input logic              sie_o,
  input logic              mie_o,
  input logic [XLEN-1:0]   scause_o,
  input logic [XLEN-1:0]   sepc_o,
  input logic [XLEN-1:0]   mcause_o,
  input logic [XLEN-1:0]   mepc_o
);
  p_irq_msb_r2: assert property (@(posedge clk) disable iff (!rst_n)
    trap_valid && trap_irq |=> (priv_o == 2'd3) ? mcause_o[XLEN-1] : scause_o[XLEN-1]);

  p_machine_stays_r5: assert property (@(posedge clk) disable iff (!rst_n)
    trap_valid && priv_o == 2'd3 |=> priv_o == 2'd3);

  p_enable_cleared_r6: assert property (@(posedge clk) disable iff (!rst_n)
    trap_valid |=> (priv_o == 2'd1 && !sie_o) || (priv_o == 2'd3 && !mie_o));

  p_epc_saved_r7: assert property (@(posedge clk) disable iff (!rst_n)
    trap_valid |=> (priv_o == 2'd3) ? (mepc_o == $past(trap_pc)) : (sepc_o == $past(trap_pc)));

  p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !trap_valid && !ctx_load |=> $stable(pc_o) && $stable(priv_o) && $stable(mcause_o)
                                 && $stable(scause_o) && $stable(sie_o) && $stable(mie_o));

  p_priv_legal_r10: assert property (@(posedge clk) disable iff (!rst_n)
    priv_o != 2'd2);
endmodule

bind trap_entry_unit trap_entry_checks #(.XLEN(XLEN), .CODE_W(CODE_W)) u_chk (.*);

// File: tb/sim_trap_entry_unit.sv
`timescale 1ns/1ps
module sim_trap_entry_unit;
  logic clk = 1'b0, rst_n = 1'b0;
  logic trap_valid = 0, trap_irq = 0, ctx_load = 0, ctx_sie = 0, ctx_mie = 0;
  logic [4:0]  trap_code = 0;
  logic [1:0]  ctx_priv = 0;
  logic [31:0] trap_addr = 0, trap_pc = 0, svec_base = 0, mvec_base = 0, exc_deleg = 0, irq_deleg = 0;
  logic [31:0] pc_o, scause_o, sepc_o, stval_o, mcause_o, mepc_o, mtval_o;
  logic [1:0]  priv_o, mpp_o;
  logic        sie_o, spie_o, spp_o, mie_o, mpie_o;

  int n_chk = 0, n_fail = 0;
  logic [31:0] e_pc, e_scause, e_sepc, e_stval, e_mcause, e_mepc, e_mtval;
  logic [1:0]  e_priv, e_mpp;
  logic        e_sie, e_spie, e_spp, e_mie, e_mpie;

  always #5 clk = ~clk;

  trap_entry_unit u0 (.*);

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic logic [31:0] f_cause(input logic irq, input logic [4:0] code, input logic [1:0] p);
    if (irq) return 32'h8000_0000 | 32'(code);
    if (code == 5'd8) return (p == 2'd0) ? 32'd8 : (p == 2'd1) ? 32'd9 : 32'd11;
    return 32'(code);
  endfunction

  function automatic logic f_addr_cause(input logic [31:0] c);
    case (c)
      32'd0, 32'd1, 32'd4, 32'd5, 32'd6, 32'd7, 32'd12, 32'd13, 32'd15: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  task automatic compare_all(input string tag);
    chk(tag, "pc", pc_o, e_pc);
    chk(tag, "priv", 32'(priv_o), 32'(e_priv));
    chk(tag, "status", {25'd0, sie_o, spie_o, spp_o, mie_o, mpie_o, mpp_o},
                       {25'd0, e_sie, e_spie, e_spp, e_mie, e_mpie, e_mpp});
    chk(tag, "scause", scause_o, e_scause);
    chk(tag, "sepc", sepc_o, e_sepc);
    chk(tag, "stval", stval_o, e_stval);
    chk(tag, "mcause", mcause_o, e_mcause);
    chk(tag, "mepc", mepc_o, e_mepc);
    chk(tag, "mtval", mtval_o, e_mtval);
  endtask

  task automatic step(input logic tv, input logic irq, input logic [4:0] code, input logic ld,
                      input logic [1:0] lp, input logic ls, input logic lm, input string tag);
    logic [31:0] c, dv;
    logic to_s;
    trap_valid = tv; trap_irq = irq; trap_code = code;
    ctx_load = ld; ctx_priv = lp; ctx_sie = ls; ctx_mie = lm;
    trap_addr = $urandom; trap_pc = $urandom;
    c = f_cause(irq, code, e_priv);
    dv = irq ? irq_deleg : exc_deleg;
    to_s = (e_priv != 2'd3) && dv[c[4:0]];
    if (tv) begin
      if (to_s) begin
        e_pc = svec_base; e_scause = c; e_sepc = trap_pc;
        e_stval = (!irq && f_addr_cause(c)) ? trap_addr : 32'd0;
        e_spie = e_sie; e_spp = e_priv[0]; e_sie = 1'b0; e_priv = 2'd1;
      end else begin
        e_pc = mvec_base; e_mcause = c; e_mepc = trap_pc;
        e_mtval = (!irq && f_addr_cause(c)) ? trap_addr : 32'd0;
        e_mpie = e_mie; e_mpp = e_priv; e_mie = 1'b0; e_priv = 2'd3;
      end
    end else if (ld) begin
      e_priv = (lp == 2'd2) ? 2'd0 : lp; e_sie = ls; e_mie = lm;
    end
    @(posedge clk);
    @(negedge clk);
    trap_valid = 0; ctx_load = 0;
    compare_all(tag);
  endtask

  initial begin
    #2_000_000;
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk + 1);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    e_pc = 32'h0000_1000; e_priv = 2'd3;
    {e_sie, e_spie, e_spp, e_mie, e_mpie} = '0; e_mpp = 0;
    {e_scause, e_sepc, e_stval, e_mcause, e_mepc, e_mtval} = '0;
    svec_base = 32'h0000_2000; mvec_base = 32'h0000_3000;
    repeat (3) @(negedge clk);
    compare_all("R1");
    rst_n = 1'b1;
    @(negedge clk);
    compare_all("R1");

    // R5: trap from M with full delegation goes to machine
    exc_deleg = '1; irq_deleg = '1;
    step(1, 0, 5'd13, 0, 0, 0, 0, "R5");
    // R10: load priv 2 becomes U
    step(0, 0, 0, 1, 2'd2, 1, 1, "R10");
    // R3: ecall from U delegated -> S, code 8
    step(1, 0, 5'd8, 0, 0, 0, 0, "R3");
    // R3: ecall from S delegated -> S, code 9
    step(1, 0, 5'd8, 0, 0, 0, 0, "R3");
    // R3: ecall from S not delegated -> M with code 9
    exc_deleg = 32'h0000_0100;
    step(1, 0, 5'd8, 0, 0, 0, 0, "R3");
    // R3: ecall from M -> 11
    step(1, 0, 5'd8, 0, 0, 0, 0, "R3");
    // R4: same code 3, exception mask set / interrupt mask clear
    step(0, 0, 0, 1, 2'd0, 1, 1, "R10");
    exc_deleg = 32'h0000_0008; irq_deleg = 32'h0;
    step(1, 1, 5'd3, 0, 0, 0, 0, "R4");
    step(0, 0, 0, 1, 2'd1, 1, 0, "R10");
    exc_deleg = 32'h0; irq_deleg = 32'h0000_0008;
    step(1, 1, 5'd3, 0, 0, 0, 0, "R4");
    // R2: high interrupt code
    step(1, 1, 5'd31, 0, 0, 0, 0, "R2");
    // R10: trap and load together, trap wins
    step(1, 0, 5'd2, 1, 2'd0, 1, 1, "R10");
    // R9: idle cycles
    step(0, 0, 5'd4, 0, 2'd1, 1, 1, "R9");
    step(0, 1, 5'd7, 0, 2'd0, 0, 1, "R9");

    for (int i = 0; i < 600; i++) begin
      int r;
      logic [4:0] code;
      r = int'($urandom % 10);
      code = ($urandom % 4 == 0) ? 5'($urandom) : 5'($urandom % 16);
      exc_deleg = $urandom; irq_deleg = $urandom;
      svec_base = $urandom & 32'hFFFF_FFFC; mvec_base = $urandom & 32'hFFFF_FFFC;
      if (r < 5) step(1, 1'($urandom), code, 1'($urandom), 2'($urandom), 1'($urandom), 1'($urandom),
                      (e_priv == 2'd3) ? "R7" : "R6");
      else if (r < 7) step(1, 0, code, 0, 0, 0, 0, "R8");
      else if (r == 7) step(0, 0, code, 1, 2'($urandom), 1'($urandom), 1'($urandom), "R10");
      else step(0, 1'($urandom), code, 0, 2'($urandom), 1'($urandom), 1'($urandom), "R9");
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule